// File: doc/BRIEF.md
# Five-Channel Prescaled Down-Counting Timer

This block is a bank of five down-counting timers behind a simple synchronous register port. Each channel has a software-visible count buffer; channels 0 to 3 also have a compare buffer. A manual-update control bit copies the buffers into the working counter and compare registers. Software then clears manual update in the same write that sets start, and the channel counts down on every divided tick.

The ticks come from two shared 8-bit prescalers, one for channels 0 and 1 and one for channels 2 to 4. Each channel then has its own power-of-two divider behind its prescaler. A channel either stops at zero (one-shot) or reloads from its count buffer (periodic). Reaching zero sets a sticky per-channel status bit, and the channel's interrupt line is that bit gated by its enable. Channels 0 to 3 each drive a PWM line that is high while the counter is above the compare value, with optional inversion. Channel 4 has no output.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0, every live count reads 0, and `irq` and `pwm_out` are all 0.
- R2: Register map and read-back masks:
  - prescaler word at 0x00 keeps bits [15:0];
  - divider word at 0x04 keeps bits [19:0];
  - control word at 0x08 keeps only bits [3:0] and [22:8] and reads bits [7:4] and [31:23] as 0;
  - count buffer of channel c is at 0x0C+12c and keeps the full counter width;
  - compare buffer of channel c (c = 0..3) is at 0x10+12c.
- R3: While a channel's manual-update bit is set, its live count (read at 0x14+12c for c = 0..3, at 0x40 for channel 4) equals its count buffer.
- R4: With auto-reload clear (one-shot), a started counter counts down to 0 and stays there, setting its status bit exactly once.
- R5: With auto-reload set (periodic) and count buffer N, status sets every (N+1) divided ticks.
- R6: Channels 0 and 1 divide by prescaler bits [7:0] plus 1; channels 2 to 4 divide by bits [15:8] plus 1.
- R7: The divider field of channel c is bits [4c+3:4c]. A value f selects a divisor of 2^(f+B), where B is 0 for a 32-bit counter and 1 for a 16-bit counter.
- R8: Interrupt word at 0x44 holds the enables in [4:0] and the status bits in [9:5]. A status bit is set when its counter steps from 1 to 0, or when it reloads 0 at zero. It stays set while its enable is 0, and `irq[c]` is status AND enable.
- R9: Status bits are write-one-to-clear. Writing 0 to a status bit leaves it unchanged, and one write can set an enable and clear its status together.
- R10: A channel whose start and manual-update bits are both 0 holds its counter value.
- R11: Each of `pwm_out[3:0]` is (counter > compare) XOR invert while its channel runs, and holds its level while the channel is stopped.
- R12: Control bit layout:
  - channel 0 uses bits [3:0];
  - channel n ≥ 1 uses the group starting at bit 4(n+1);
  - within a group, bit 0 is start, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload;
  - channel 4 has no invert bit and its auto-reload is absolute bit 22.
- R13: Writing ones to control bits [7:4] starts no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 5 | Per-channel interrupt, status AND enable |
| pwm_out | output | 4 | PWM lines of channels 0 to 3 |

## Verification
The counting function is tried in three ways. One-shot runs confirm that the count parks at zero and raises a single event. Periodic runs measure the exact number of cycles between two status events. Compare settings put the counter above and below the compare value. The periodic intervals are repeated with different prescaler words, divider fields and channels. This shows which prescaler group a channel uses, where its divider field sits, and where channel 4's reload bit lies. Status is read with the enable both off and on, and cleared with and without a set enable, which separates the sticky status from the gated interrupt line.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 5;   // timer channels
  localparam int NOUT   = 4;   // channels with a PWM line
  localparam int PRE_W  = 8;   // prescaler width
  localparam int DIV_W  = 16;  // free-running divider counter width
  localparam int DATA_W = 32;
  localparam int CTL_W  = 23;

  localparam logic [7:0] A_PRE = 8'h00;
  localparam logic [7:0] A_DIV = 8'h04;
  localparam logic [7:0] A_CTL = 8'h08;
  localparam logic [7:0] A_INT = 8'h44;
  localparam logic [CTL_W-1:0] CTL_KEEP = 23'h7FFF0F;

  function automatic logic [7:0] addr_cnt(input int ch);
    return 8'(12 * ch + 12);
  endfunction

  function automatic logic [7:0] addr_cmp(input int ch);
    return 8'(12 * ch + 16);
  endfunction

  function automatic logic [7:0] addr_live(input int ch);
    return (ch == NCH - 1) ? 8'h40 : 8'(12 * ch + 20);
  endfunction

  // Control group start: channel 0 at 0, then a one-group gap.
  function automatic int ctl_base(input int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_val,
  output logic             pre_tick,
  output logic [DIV_W-1:0] div_cnt
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    pre_tick = (pre_q >= pre_val);
    pre_d    = pre_tick ? '0 : pre_q + 1'b1;
    div_d    = pre_tick ? div_q + 1'b1 : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  assign div_cnt = div_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BASE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] div_cnt,
  input  logic [3:0]       div_sel,
  input  logic             start,
  input  logic             manual,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] cnt_buf,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] mask;
  logic [4:0]       k;
  logic             tick;

  always_comb begin
    k = 5'(div_sel) + 5'(BASE);
    for (int i = 0; i < DIV_W; i++) mask[i] = (5'(i) < k);
    tick = pre_tick && ((div_cnt & mask) == mask);
  end

  always_comb begin
    cnt_d    = cnt_q;
    zero_evt = 1'b0;
    if (manual) begin
      cnt_d = cnt_buf;
    end else if (start && tick) begin
      if (cnt_q == '0) begin
        if (reload_en) begin
          cnt_d    = cnt_buf;
          zero_evt = (cnt_buf == '0);
        end
      end else begin
        cnt_d    = cnt_q - 1'b1;
        zero_evt = (cnt_q == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_manual_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> (cnt_q == $past(cnt_buf)));
  p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !manual && !reload_en && cnt_q == '0) |=> (cnt_q == '0));
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !manual) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             manual,
  input  logic             inv,
  input  logic [CNT_W-1:0] cmp_buf,
  input  logic [CNT_W-1:0] cnt,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             pwm_q, pwm_d;
  logic             run;

  always_comb begin
    run   = start && !manual;
    cmp_d = manual ? cmp_buf : cmp_q;
    pwm_d = run ? ((cnt > cmp_q) ^ inv) : pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  p_pwm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !manual) |=> $stable(pwm_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irq,
  output logic [NOUT-1:0]   pwm_out
);
  localparam int BASE = (CNT_W == 16) ? 1 : 0;

  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  logic [2*PRE_W-1:0] pre_q, pre_d;
  logic [4*NCH-1:0]   div_q, div_d;
  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic [NCH-1:0]     en_q, en_d, st_q, st_d, clr_vec, evt;
  logic [CNT_W-1:0]   cbuf_q [NCH];
  logic [CNT_W-1:0]   cbuf_d [NCH];
  logic [CNT_W-1:0]   mbuf_q [NOUT];
  logic [CNT_W-1:0]   mbuf_d [NOUT];
  logic [CNT_W-1:0]   live [NCH];
  logic [1:0]         pre_tick;
  logic [DIV_W-1:0]   div_cnt [2];

  always_comb begin
    pre_d   = pre_q;
    div_d   = div_q;
    ctl_d   = ctl_q;
    en_d    = en_q;
    cbuf_d  = cbuf_q;
    mbuf_d  = mbuf_q;
    clr_vec = '0;
    if (we) begin
      if (addr == A_PRE) pre_d = wdata[2*PRE_W-1:0];
      if (addr == A_DIV) div_d = wdata[4*NCH-1:0];
      if (addr == A_CTL) ctl_d = wdata[CTL_W-1:0] & CTL_KEEP;
      if (addr == A_INT) begin
        en_d    = wdata[NCH-1:0];
        clr_vec = wdata[2*NCH-1:NCH];
      end
      for (int i = 0; i < NCH; i++)
        if (addr == addr_cnt(i)) cbuf_d[i] = wdata[CNT_W-1:0];
      for (int i = 0; i < NOUT; i++)
        if (addr == addr_cmp(i)) mbuf_d[i] = wdata[CNT_W-1:0];
    end
    st_d = (st_q & ~clr_vec) | evt;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pre_q <= '0;
      div_q <= '0;
      ctl_q <= '0;
      en_q  <= '0;
      st_q  <= '0;
      for (int i = 0; i < NCH; i++)  cbuf_q[i] <= '0;
      for (int i = 0; i < NOUT; i++) mbuf_q[i] <= '0;
    end else begin
      pre_q  <= pre_d;
      div_q  <= div_d;
      ctl_q  <= ctl_d;
      en_q   <= en_d;
      st_q   <= st_d;
      cbuf_q <= cbuf_d;
      mbuf_q <= mbuf_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_PRE) rdata = DATA_W'(pre_q);
    if (addr == A_DIV) rdata = DATA_W'(div_q);
    if (addr == A_CTL) rdata = DATA_W'(ctl_q);
    if (addr == A_INT) rdata = DATA_W'({st_q, en_q});
    for (int i = 0; i < NCH; i++) begin
      if (addr == addr_cnt(i))  rdata = DATA_W'(cbuf_q[i]);
      if (addr == addr_live(i)) rdata = DATA_W'(live[i]);
    end
    for (int i = 0; i < NOUT; i++)
      if (addr == addr_cmp(i)) rdata = DATA_W'(mbuf_q[i]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_pre
    tmr_prescale u_pre (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .pre_val (pre_q[PRE_W*g +: PRE_W]),
      .pre_tick(pre_tick[g]),
      .div_cnt (div_cnt[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int G  = (c < 2) ? 0 : 1;
    localparam int B  = ctl_base(c);
    localparam int AR = (c == NCH - 1) ? B + 2 : B + 3;

    tmr_channel #(.CNT_W(CNT_W), .BASE(BASE)) u_ch (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .pre_tick (pre_tick[G]),
      .div_cnt  (div_cnt[G]),
      .div_sel  (div_q[4*c +: 4]),
      .start    (ctl_q[B]),
      .manual   (ctl_q[B+1]),
      .reload_en(ctl_q[AR]),
      .cnt_buf  (cbuf_q[c]),
      .cnt_o    (live[c]),
      .zero_evt (evt[c])
    );

    if (c < NOUT) begin : g_out
      tmr_pwm #(.CNT_W(CNT_W)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_q_n),
        .start  (ctl_q[B]),
        .manual (ctl_q[B+1]),
        .inv    (ctl_q[B+2]),
        .cmp_buf(mbuf_q[c]),
        .cnt    (live[c]),
        .pwm_o  (pwm_out[c])
      );
    end
  end

  assign irq = st_q & en_q;

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|(clr_vec & ~evt)) |=> ((st_q & $past(clr_vec & ~evt)) == '0));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|(st_q & ~clr_vec)) |=> (($past(st_q & ~clr_vec) & ~st_q) == '0));
endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  irq;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_bank u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic int gbase(input int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  function automatic int arbit(input int ch);
    return (ch == 4) ? gbase(ch) + 2 : gbase(ch) + 3;
  endfunction

  function automatic logic [7:0] live_a(input int ch);
    return (ch == 4) ? 8'h40 : 8'(8'h14 + 12 * ch);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 prescaler", v, 0);
    rd(8'h04, v); chk("R1 divider", v, 0);
    rd(8'h08, v); chk("R1 control", v, 0);
    rd(8'h44, v); chk("R1 interrupt", v, 0);
    rd(8'h40, v); chk("R1 live ch4", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pwm", 32'(pwm_out), 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 prescaler mask", v, 32'h0000_FFFF);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 divider mask", v, 32'h000F_FFFF);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R2 control mask", v, 32'h007F_FF0F);
    wr(8'h08, 0);
    wr(8'h00, 0); wr(8'h04, 0);
    wr(8'h24, 32'hDEAD_BEEF); rd(8'h24, v); chk("R2 count buffer ch2", v, 32'hDEAD_BEEF);
    wr(8'h34, 32'h1234_5678); rd(8'h34, v); chk("R2 compare buffer ch3", v, 32'h1234_5678);
  endtask

  task automatic t_manual;
    logic [31:0] v;
    wr(8'h18, 77);
    wr(8'h08, 32'(1) << (gbase(1) + 1));
    rd(live_a(1), v); chk("R3 live ch1 after manual", v, 77);
    wr(8'h3C, 55);
    wr(8'h08, 32'(1) << (gbase(4) + 1));
    rd(8'h40, v); chk("R3 live ch4 after manual", v, 55);
    wr(8'h08, 32'h0000_00F0);
    repeat (10) @(negedge clk);
    rd(live_a(1), v); chk("R13 ch1 not started by bits 7:4", v, 77);
    rd(8'h08, v); chk("R13 bits 7:4 read zero", v, 0);
    rd(8'h40, v); chk("R10 stopped ch4 holds", v, 55);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h44, 32'h3E0);
    wr(8'h0C, 5);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    repeat (20) @(negedge clk);
    rd(live_a(0), v); chk("R4 one-shot parks at zero", v, 0);
    chk("R8 irq low with enable off", 32'(irq[0]), 0);
    rd(8'h44, v); chk("R8 status set with enable off", v, 32'h20);
    wr(8'h44, 32'h1);
    rd(8'h44, v); chk("R9 writing zero keeps status", v, 32'h21);
    chk("R8 irq follows enable", 32'(irq[0]), 1);
    wr(8'h44, 32'h21);
    rd(8'h44, v); chk("R9 enable and clear together", v, 32'h01);
    chk("R9 irq low after clear", 32'(irq[0]), 0);
    repeat (20) @(negedge clk);
    chk("R4 single event only", 32'(irq[0]), 0);
    rd(live_a(0), v); chk("R4 still zero", v, 0);
    wr(8'h08, 0); wr(8'h44, 32'h3E0);
  endtask

  task automatic t_period(input string tag, input int ch, input logic [31:0] prew,
                          input logic [31:0] divw, input int n, input int exp);
    int t1;
    int g;
    wr(8'h00, prew); wr(8'h04, divw);
    wr(8'(8'h0C + 12 * ch), 32'(n));
    wr(8'h08, (32'(1) << (gbase(ch) + 1)) | (32'(1) << arbit(ch)));
    wr(8'h44, 32'h3E0 | (32'(1) << ch));
    wr(8'h08, (32'(1) << gbase(ch)) | (32'(1) << arbit(ch)));
    g = 0;
    while (!irq[ch] && g < 5000) begin @(negedge clk); g++; end
    t1 = cyc;
    wr(8'h44, (32'(1) << ch) | (32'(1) << (ch + 5)));
    while (!irq[ch] && g < 10000) begin @(negedge clk); g++; end
    chk(tag, 32'(cyc - t1), 32'(exp));
    wr(8'h08, 0); wr(8'h44, 32'h3E0);
  endtask

  task automatic t_pwm;
    wr(8'h00, 0); wr(8'h04, 0);
    wr(8'h0C, 200); wr(8'h10, 100);
    wr(8'h08, 32'hA);
    wr(8'h08, 32'h9);
    repeat (5) @(negedge clk);
    chk("R11 pwm high above compare", 32'(pwm_out[0]), 1);
    wr(8'h08, 32'hD);
    repeat (3) @(negedge clk);
    chk("R11 pwm inverted", 32'(pwm_out[0]), 0);
    wr(8'h08, 32'h0);
    repeat (5) @(negedge clk);
    chk("R11 pwm holds while stopped", 32'(pwm_out[0]), 0);
    wr(8'h08, 32'h8);
    repeat (3) @(negedge clk);
    chk("R11 pwm holds despite invert change", 32'(pwm_out[0]), 0);
    wr(8'h0C, 5);
    wr(8'h08, 32'hA);
    wr(8'h08, 32'h1);
    repeat (3) @(negedge clk);
    chk("R11 pwm low at or below compare", 32'(pwm_out[0]), 0);
    wr(8'h08, 0); wr(8'h44, 32'h3E0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_map;
    t_manual;
    t_oneshot;
    t_period("R5 periodic ch0 N=3", 0, 0, 0, 3, 4);
    t_period("R5 periodic ch3 N=9", 3, 0, 0, 9, 10);
    t_period("R6 ch2 uses upper prescaler", 2, 32'h0300, 0, 3, 16);
    t_period("R6 ch1 uses lower prescaler", 1, 32'h0300, 0, 3, 4);
    t_period("R7 ch1 divider field 2", 1, 0, 32'h0000_0020, 3, 16);
    t_period("R12 ch4 auto-reload at bit 22", 4, 0, 0, 4, 5);
    t_pwm;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule